// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block sits next to the ECC checker of a memory controller and keeps a record of the first ECC error it sees. The checker signals each transaction's errors with three strobes: a corrected single-bit error, an uncorrectable double-bit error, and a corrected error in a check bit. With them it supplies the 8-bit syndrome, a 4-bit transaction size code, the direction of the access, and the failing address. When any strobe fires while the register is empty, all of this is stored on one clock edge. The record is then frozen, and later errors are ignored until software clears it.

Software reads a 32-bit status word and a companion address word through a small register port. Any write to the status word clears both words, whatever data is written. The address word is read-only. The status word uses big-endian bit numbering, where bit 0 is the most significant bit. The bit positions are fixed because software decodes the fields at those positions.

Top module: `ecc_err_status`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `status_word` and `err_addr` are all zero.
- R2: Field layout of `status_word`. In big-endian numbering, bits 0..15 read zero, the size code is at 16..19, the direction flag at 20, the syndrome at 21..28, the check-bit flag at 29, the double-bit flag at 30 and the single-bit flag at 31. In vector terms this is {16'b0, size[3:0], dir, syndrome[7:0], check, double, single}.
- R3: The register is armed when its three flag bits are all zero. When any strobe is high while armed, the next clock edge loads size, direction, syndrome, all three flags and the address together. With no strobe, the words do not change.
- R4: While any flag bit is set, new strobes change neither `status_word` nor `err_addr`.
- R5: A write with `bus_sel`=0 clears both words at the next edge, for any value of `bus_wdata`.
- R6: If a clearing write and a strobe arrive in the same cycle, the clear wins. The strobe is dropped, and the register stays armed for the next error.
- R7: An event with only the double-bit strobe still loads the supplied syndrome into the syndrome field.
- R8: A write with `bus_sel`=1 (the address word) has no effect on either word.
- R9: `bus_rdata` returns `status_word` when `bus_sel`=0 and the zero-extended `err_addr` when `bus_sel`=1, in the same cycle.
- R10: The direction flag stores `err_is_read`. It is 1 for a read and 0 for a write that used a read-modify-write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_single | input | 1 | Corrected single-bit error strobe |
| err_double | input | 1 | Uncorrectable double-bit error strobe |
| err_check | input | 1 | Corrected check-bit error strobe |
| err_syndrome | input | 8 | Syndrome from the checker |
| err_size | input | 4 | Transaction size code |
| err_is_read | input | 1 | 1 = read, 0 = read-modify-write |
| err_addr_in | input | ADDR_W | Address of the transaction |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = status word, 1 = address word |
| bus_wdata | input | 32 | Write data (not stored) |
| bus_rdata | output | 32 | Read data for `bus_sel` |
| status_word | output | 32 | Captured status word |
| err_addr | output | ADDR_W | Captured error address |

## Verification
A strobe or a write presented in one cycle shows up in `status_word` and `err_addr` one clock edge later. `bus_rdata` follows `bus_sel` in the same cycle. The bench drives inputs on the falling edge, and its reference model updates on the rising edge. It compares at the next falling edge, so each comparison sees the result due exactly one edge after its stimulus. Directed cases with literal expected words cover the first-error load, the frozen hold, clear priority and the double-bit syndrome. A randomized stretch then compares every cycle.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int SIZE_W = 4;
  localparam int SYND_W = 8;
  localparam int WORD_W = 32;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              is_read;
    logic [SYND_W-1:0] synd;
    logic              chk;
    logic              dbl;
    logic              sgl;
  } capture_t;

  localparam int CAP_W = $bits(capture_t);
  localparam int PAD_W = WORD_W - CAP_W;

  // Big-endian bit k of the word is vector bit WORD_W-1-k, so the
  // struct occupies the low half with single-bit at vector bit 0.
  function automatic logic [WORD_W-1:0] pack_status(input capture_t c);
    return {{PAD_W{1'b0}}, c};
  endfunction

  function automatic logic [FLAG_W-1:0] flags_of(input capture_t c);
    return {c.chk, c.dbl, c.sgl};
  endfunction
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  input  logic              err_any,
  input  logic [FLAG_W-1:0] flags_q,
  output logic              armed,
  output logic              load,
  output logic              clr
);
  assign armed = (flags_q == '0);
  assign clr   = clr_req;
  assign load  = armed && err_any && !clr_req;

  // R6: a clear beside a strobe leaves the register armed
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_req && err_any) |=> armed);
  // R3: a load raises at least one flag
  a_r3_load_sets_flag: assert property (@(posedge clk) disable iff (rst)
    load |=> !armed);
  // R4: no load while disarmed
  a_r4_no_load_disarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !load);
endmodule

// File: rtl/ecc_cap_hold.sv
module ecc_cap_hold
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clr,
  input  capture_t          cap_in,
  input  logic [ADDR_W-1:0] addr_in,
  output capture_t          cap_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cap_q  <= '0;
      addr_q <= '0;
    end else if (load) begin
      cap_q  <= cap_in;
      addr_q <= addr_in;
    end
  end

  // R5: a clear empties both words
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cap_q == '0 && addr_q == '0));
  // R4: without load or clear the record is frozen
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> ($stable(cap_q) && $stable(addr_q)));
  // R3: load copies the inputs
  a_r3_load_copies: assert property (@(posedge clk) disable iff (rst)
    load |=> (cap_q == $past(cap_in) && addr_q == $past(addr_in)));
endmodule

// File: rtl/ecc_cap_rdmux.sv
module ecc_cap_rdmux
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              sel,
  input  logic [WORD_W-1:0] status,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rdata
);
  always_comb begin
    if (sel) rdata = WORD_W'(addr);
    else     rdata = status;
  end
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_single,
  input  logic              err_double,
  input  logic              err_check,
  input  logic [7:0]        err_syndrome,
  input  logic [3:0]        err_size,
  input  logic              err_is_read,
  input  logic [ADDR_W-1:0] err_addr_in,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       status_word,
  output logic [ADDR_W-1:0] err_addr
);
  capture_t cap_in, cap_q;
  logic     err_any, clr_req, armed, load, clr;

  assign err_any = err_single | err_double | err_check;
  assign clr_req = bus_wr && !bus_sel;

  always_comb begin
    cap_in.size    = err_size;
    cap_in.is_read = err_is_read;
    cap_in.synd    = err_syndrome;
    cap_in.chk     = err_check;
    cap_in.dbl     = err_double;
    cap_in.sgl     = err_single;
  end

  ecc_cap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clr_req(clr_req), .err_any(err_any),
    .flags_q(flags_of(cap_q)), .armed(armed), .load(load), .clr(clr)
  );

  ecc_cap_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .clr(clr), .cap_in(cap_in),
    .addr_in(err_addr_in), .cap_q(cap_q), .addr_q(err_addr)
  );

  assign status_word = pack_status(cap_q);

  ecc_cap_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .sel(bus_sel), .status(status_word), .addr(err_addr), .rdata(bus_rdata)
  );

  // R2: reserved half reads zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_word[31:16] == 16'h0);
  // R5: clear independent of write data
  a_r5_any_data: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_sel && bus_wdata != 32'h0) |=> status_word == 32'h0);
  // R8: address-word write leaves the address alone unless a capture loads
  a_r8_addr_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && !load) |=> $stable(err_addr));
  // R7: double-only capture keeps the syndrome
  a_r7_dbl_synd: assert property (@(posedge clk) disable iff (rst)
    (load && err_double && !err_single && !err_check) |=>
      status_word[10:3] == $past(err_syndrome));
endmodule

// File: tb/ecc_err_status_test.sv
module ecc_err_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WATCHDOG = 20000;

  logic          clk = 0;
  logic          rst = 1;
  logic          e_s = 0, e_d = 0, e_c = 0, e_rd = 0;
  logic [7:0]    e_syn = 0;
  logic [3:0]    e_sz = 0;
  logic [AW-1:0] e_addr = 0;
  logic          wr = 0, sel = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata, status;
  logic [AW-1:0] eaddr;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  longint unsigned m_status = 0, m_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_status #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .err_single(e_s), .err_double(e_d), .err_check(e_c),
    .err_syndrome(e_syn), .err_size(e_sz), .err_is_read(e_rd),
    .err_addr_in(e_addr), .bus_wr(wr), .bus_sel(sel), .bus_wdata(wdata),
    .bus_rdata(rdata), .status_word(status), .err_addr(eaddr)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_status <= 0; m_addr <= 0;
    end else if (wr && sel == 0) begin
      m_status <= 0; m_addr <= 0;
    end else if ((m_status % 8) == 0 && (e_s || e_d || e_c)) begin
      m_status <= e_sz * 4096 + e_rd * 2048 + e_syn * 8 + e_c * 4 + e_d * 2 + e_s;
      m_addr   <= e_addr;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    check(cur_req, "status", status, m_status);
    check(cur_req, "addr", eaddr, m_addr);
    check("R9", "rdata", rdata, sel ? m_addr : m_status);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic quiet();
    e_s = 0; e_d = 0; e_c = 0; wr = 0; wdata = 0;
  endtask

  initial begin
    @(negedge clk); tick(); rst = 0;
    cur_req = "R1";
    check("R1", "reset status", status, 0);
    check("R1", "reset addr", eaddr, 0);

    // R3/R2/R10: first single-bit error on a read
    cur_req = "R3";
    e_s = 1; e_sz = 4'hA; e_rd = 1; e_syn = 8'h5C; e_addr = 32'h1234_5678;
    tick(); quiet();
    check("R2", "layout single", status, 32'h0000_AAE1);
    check("R10", "read dir", status[11], 1);
    check("R3", "addr loaded", eaddr, 32'h1234_5678);

    // R4: later error ignored
    cur_req = "R4";
    e_d = 1; e_sz = 4'h3; e_syn = 8'hFF; e_addr = 32'hCAFE_0000;
    tick(); tick(); quiet();
    check("R4", "held status", status, 32'h0000_AAE1);
    check("R4", "held addr", eaddr, 32'h1234_5678);

    // R8/R9: write to address word ignored, read back address
    cur_req = "R8";
    wr = 1; sel = 1; wdata = 32'hFFFF_FFFF;
    tick(); quiet();
    check("R8", "addr after ro write", eaddr, 32'h1234_5678);
    check("R9", "rdata addr", rdata, 32'h1234_5678);
    sel = 0; #1;
    check("R9", "rdata status", rdata, 32'h0000_AAE1);

    // R5: clear with zero data
    cur_req = "R5";
    wr = 1; sel = 0; wdata = 0;
    tick(); quiet();
    check("R5", "cleared status", status, 0);
    check("R5", "cleared addr", eaddr, 0);

    // R7/R10: double-only on an RMW write
    cur_req = "R7";
    e_d = 1; e_sz = 4'h3; e_rd = 0; e_syn = 8'h81; e_addr = 32'h0000_0040;
    tick(); quiet();
    check("R7", "double syndrome", status, 32'h0000_340A);
    check("R10", "write dir", status[11], 0);

    // R6: clear with data beside a check-bit strobe
    cur_req = "R6";
    wr = 1; sel = 0; wdata = 32'hDEAD_BEEF; e_c = 1; e_syn = 8'h11; e_addr = 32'h99;
    tick(); quiet();
    check("R6", "clear wins", status, 0);
    e_c = 1; e_sz = 4'h1; e_rd = 1; e_syn = 8'h00; e_addr = 32'h77;
    tick(); quiet();
    check("R6", "armed after clear", status, 32'h0000_1804);
    check("R6", "addr after rearm", eaddr, 32'h77);

    // R3: randomized stretch
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      e_s = ($urandom % 6) == 0; e_d = ($urandom % 8) == 0; e_c = ($urandom % 8) == 0;
      e_sz = 4'($urandom); e_rd = 1'($urandom); e_syn = 8'($urandom);
      e_addr = $urandom; sel = 1'($urandom);
      wr = ($urandom % 10) == 0; wdata = $urandom;
      tick();
    end
    quiet();
    tick();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule